// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-on to a usable state without any software involvement. When a single-cycle start pulse arrives it captures the configuration inputs, puts one NOP on the command output, and then holds off for the power-up interval. After that it emits a precharge, a run of auto-refresh commands and finally a mode register set. Every command is marked by a one-cycle issue strobe, and consecutive commands are separated by a minimum spacing.

The value written by the mode register set is computed in hardware from the CAS latency code and the bus-width select. A nonzero override input takes its place when it is supplied. The refresh-enable output stays low while the sequence runs, so that a periodic refresh scheduler elsewhere cannot disturb it. Refresh enable goes high once the mode register set has gone out. A done flag follows one cycle later and holds until reset. All delays are counted in clock cycles. The counts are rounded up at elaboration from the clock-frequency parameter, so the minimum times are always met.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: After reset, cmd is NOP (2'd0), cmd_issue, refresh_en and done are 0, and mode_data is 0.
- R2: A start pulse seen while idle makes the block issue a NOP in the next cycle. The PRECHARGE follows exactly WAIT_CYC cycles later, where WAIT_CYC = ceil(CLK_HZ * PWRUP_NS / 1e9), with a minimum of 1.
- R3: After the NOP, the commands come in the order PRECHARGE, then NUM_REF (default 8) AUTO-REFRESH, then one MODE REGISTER SET. The cmd encoding is NOP=2'd0, PRECHARGE=2'd1, AUTO-REFRESH=2'd2, MODE REGISTER SET=2'd3.
- R4: From the PRECHARGE onward, consecutive commands are exactly GAP_CYC cycles apart, where GAP_CYC = ceil(CLK_HZ * GAP_NS / 1e9), with a minimum of 1 (GAP_NS defaults to 80).
- R5: Each command is presented for one cycle, with cmd_issue high in that cycle. In every other cycle cmd_issue is low and cmd is NOP.
- R6: mode_data carries the mode value only in the MODE REGISTER SET cycle and is 0 in every other cycle. A cl_code of 3'd2 selects CAS latency 2, and any other value selects CAS latency 3. With half_width=0 (32-bit bus) the value is 0x40 for CL2 and 0x60 for CL3. With half_width=1 (16-bit bus) it is 0x20 for CL2 and 0x30 for CL3.
- R7: A nonzero mode_override replaces the computed mode value. A zero override leaves the computed value in place.
- R8: cl_code, half_width and mode_override are sampled in the start cycle. Changing them later has no effect on the sequence.
- R9: refresh_en is 0 from the start until the MODE REGISTER SET cycle, inclusive. It is 1 from the following cycle onward, until reset.
- R10: done rises exactly one cycle after refresh_en and stays 1 until reset.
- R11: Start pulses that arrive while the sequence is running, or after it has finished, are ignored. They cause no extra command and no change in timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts the sequence when idle |
| cl_code | input | 3 | CAS latency code (2 means CL2, other values mean CL3) |
| half_width | input | 1 | 1 selects a 16-bit bus, 0 selects a 32-bit bus |
| mode_override | input | 8 | Nonzero value replaces the computed mode data |
| cmd | output | 2 | SDRAM command code |
| cmd_issue | output | 1 | High in each cycle that carries an issued command |
| mode_data | output | 8 | Mode register value during MODE REGISTER SET, 0 otherwise |
| refresh_en | output | 1 | Permits periodic refresh once initialization ends |
| done | output | 1 | Initialization complete |

## Verification
The hardest conditions to reach from the ports are a start pulse that lands in the middle of the long power-up wait, and configuration inputs that change after capture. Each bench run pulses start again partway through the wait and scrambles cl_code, half_width and mode_override right after the start cycle. It then checks that the command timeline and the mode value still follow the originally captured values. The bench shortens the power-up interval through its parameter and sweeps all cl_code and width combinations, plus two override values, each from a fresh reset.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

    localparam int MODE_W = 8;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_MRS = 2'd3
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_SEQ,
        ST_HOLD,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [2:0]        cl;
        logic              half;
        logic [MODE_W-1:0] ovr;
    } init_cfg_t;

    // Convert a duration in ns to clock cycles, rounding up.
    function automatic longint unsigned ns_to_cycles(longint unsigned hz,
                                                     longint unsigned ns);
        return (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

    // Mode register value from the captured configuration.
    function automatic logic [MODE_W-1:0] calc_mode(init_cfg_t c);
        logic [MODE_W-1:0] v;
        v = (c.cl == 3'd2) ? MODE_W'(8'h40) : MODE_W'(8'h60);
        if (c.half) v = v >> 1;
        if (c.ovr != '0) v = c.ovr;
        return v;
    endfunction

endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_pwrup_mode.sv
module sdram_pwrup_mode
    import sdram_pwrup_pkg::*;
(
    input  init_cfg_t         cfg,
    output logic [MODE_W-1:0] value
);
    always_comb value = calc_mode(cfg);
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_pwrup_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 100_000_000,
    parameter longint unsigned PWRUP_NS = 200_000,
    parameter longint unsigned GAP_NS   = 80,
    parameter int              NUM_REF  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        cl_code,
    input  logic              half_width,
    input  logic [MODE_W-1:0] mode_override,
    output logic [1:0]        cmd,
    output logic              cmd_issue,
    output logic [MODE_W-1:0] mode_data,
    output logic              refresh_en,
    output logic              done
);
    localparam longint unsigned WAIT_RAW = ns_to_cycles(CLK_HZ, PWRUP_NS);
    localparam longint unsigned GAP_RAW  = ns_to_cycles(CLK_HZ, GAP_NS);
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : int'(WAIT_RAW);
    localparam int GAP_CYC  = (GAP_RAW  < 1) ? 1 : int'(GAP_RAW);
    localparam int TW = $clog2(WAIT_CYC + 1) + 1;
    localparam int IW = $clog2(NUM_REF + 2);
    localparam logic [TW-1:0] WAIT_LD = TW'(WAIT_CYC - 1);
    localparam logic [TW-1:0] GAP_LD  = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] WAIT_T  = TW'(WAIT_CYC);
    localparam logic [TW-1:0] GAP_T   = TW'(GAP_CYC);
    localparam logic [IW-1:0] LAST_IX = IW'(NUM_REF + 1);

    seq_state_e        st_q;
    sdr_cmd_e          cmd_q;
    logic              iss_q, ref_q, done_q;
    logic [MODE_W-1:0] mode_q, mode_val;
    logic [IW-1:0]     idx_q;
    init_cfg_t         cfg_q, cfg_in;
    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_val;

    assign cfg_in = '{cl: cl_code, half: half_width, ovr: mode_override};

    always_comb begin
        tmr_load = ((st_q == ST_IDLE) && start) ||
                   (((st_q == ST_PWR) || (st_q == ST_SEQ)) && tmr_exp);
        tmr_val  = (st_q == ST_IDLE) ? WAIT_LD : GAP_LD;
    end

    sdram_pwrup_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sdram_pwrup_mode u_mode (
        .cfg   (cfg_q),
        .value (mode_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cmd_q  <= CMD_NOP;
            iss_q  <= 1'b0;
            mode_q <= '0;
            ref_q  <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
            cfg_q  <= '0;
        end else begin
            cmd_q  <= CMD_NOP;
            iss_q  <= 1'b0;
            mode_q <= '0;
            done_q <= ref_q;
            case (st_q)
                ST_IDLE: if (start) begin
                    cfg_q <= cfg_in;
                    iss_q <= 1'b1;
                    st_q  <= ST_PWR;
                end
                ST_PWR: if (tmr_exp) begin
                    cmd_q <= CMD_PRE;
                    iss_q <= 1'b1;
                    idx_q <= IW'(1);
                    st_q  <= ST_SEQ;
                end
                ST_SEQ: if (tmr_exp) begin
                    iss_q <= 1'b1;
                    if (idx_q == LAST_IX) begin
                        cmd_q  <= CMD_MRS;
                        mode_q <= mode_val;
                        st_q   <= ST_HOLD;
                    end else begin
                        cmd_q <= CMD_REF;
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    ref_q <= 1'b1;
                    st_q  <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    assign cmd        = cmd_q;
    assign cmd_issue  = iss_q;
    assign mode_data  = mode_q;
    assign refresh_en = ref_q;
    assign done       = done_q;

    // Spacing monitor: cycles since the previous issue, saturating.
    logic [TW-1:0] since_q;
    logic          seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (iss_q) begin
            since_q <= TW'(1);
            seen_q  <= 1'b1;
        end else if (since_q < WAIT_T) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r2_pwrup_wait: assert property (@(posedge clk) disable iff (rst)
        (iss_q && cmd_q == CMD_PRE) |-> (seen_q && since_q == WAIT_T));
    a_r4_min_gap: assert property (@(posedge clk) disable iff (rst)
        (iss_q && seen_q && cmd_q != CMD_PRE) |-> (since_q >= GAP_T));
    a_r5_nop_idle: assert property (@(posedge clk) disable iff (rst)
        !iss_q |-> (cmd_q == CMD_NOP));
    a_r6_mode_only_mrs: assert property (@(posedge clk) disable iff (rst)
        (mode_q != '0) |-> (iss_q && cmd_q == CMD_MRS));
    a_r9_refresh_off: assert property (@(posedge clk) disable iff (rst)
        iss_q |-> !ref_q);
    a_r9_refresh_sticky: assert property (@(posedge clk) disable iff (rst)
        ref_q |=> ref_q);
    a_r10_done_implies_ref: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (ref_q && !iss_q));
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DONE && start) |=> !iss_q);
endmodule

// File: tb/tb_sdram_pwrup_seq.sv
module tb_sdram_pwrup_seq;
    localparam longint unsigned CLK_HZ   = 200_000_000;
    localparam longint unsigned PWRUP_NS = 20_000;
    localparam longint unsigned GAP_NS   = 80;
    localparam int NREF = 8;
    localparam longint unsigned W_RAW = (CLK_HZ * PWRUP_NS + 999_999_999) / 1_000_000_000;
    localparam longint unsigned G_RAW = (CLK_HZ * GAP_NS + 999_999_999) / 1_000_000_000;
    localparam int EW = (W_RAW < 1) ? 1 : int'(W_RAW);
    localparam int EG = (G_RAW < 1) ? 1 : int'(G_RAW);
    localparam int NCMD = NREF + 3;
    localparam int M_AT = EW + (NREF + 1) * EG;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] cl_code = 3'd0;
    logic       half_width = 1'b0;
    logic [7:0] mode_override = 8'd0;
    logic [1:0] cmd;
    logic       cmd_issue;
    logic [7:0] mode_data;
    logic       refresh_en, done;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sdram_pwrup_seq #(.CLK_HZ(CLK_HZ), .PWRUP_NS(PWRUP_NS), .GAP_NS(GAP_NS),
                      .NUM_REF(NREF)) dut (
        .clk(clk), .rst(rst), .start(start), .cl_code(cl_code),
        .half_width(half_width), .mode_override(mode_override), .cmd(cmd),
        .cmd_issue(cmd_issue), .mode_data(mode_data), .refresh_en(refresh_en),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cmd(input int j);
        if (j == 0) return 0;
        if (j == 1) return 1;
        if (j <= NREF + 1) return 2;
        return 3;
    endfunction

    function automatic int exp_time(input int j);
        return (j == 0) ? 0 : EW + (j - 1) * EG;
    endfunction

    task automatic run_seq(input logic [2:0] cl, input logic hw, input logic [7:0] ovr);
        int n_iss = 0, bad_ix = -1, bad_act_c = 0, bad_act_t = 0;
        int mrs_val = -1, stray_mode = 0, stray_cmd = 0, ref_early = 0;
        int ref_at = 0, done_at = 0, exp_m;
        exp_m = (cl == 3'd2) ? 'h40 : 'h60;
        if (hw) exp_m = exp_m / 2;
        if (ovr != 8'd0) exp_m = ovr;

        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(cmd == 2'd0 && !cmd_issue && !refresh_en && !done && mode_data == 0,
            "R1", "idle outputs after reset",
            {cmd, cmd_issue, refresh_en, done, (mode_data != 0)}, 0);

        cl_code = cl; half_width = hw; mode_override = ovr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: scramble configuration after capture
        cl_code = ~cl; half_width = ~hw; mode_override = ovr ^ 8'hA5;

        for (int k = 0; k <= M_AT + 2; k++) begin
            if (k == 50) start = 1'b1;
            if (k == 51) start = 1'b0;
            if (cmd_issue) begin
                if (n_iss < NCMD && bad_ix < 0 &&
                    (int'(cmd) != exp_cmd(n_iss) || k != exp_time(n_iss))) begin
                    bad_ix = n_iss; bad_act_c = cmd; bad_act_t = k;
                end
                if (cmd == 2'd3) mrs_val = mode_data;
                else if (mode_data != 0) stray_mode++;
                n_iss++;
            end else if (cmd != 2'd0 || mode_data != 0) begin
                stray_cmd++;
            end
            if (k <= M_AT && refresh_en) ref_early++;
            if (k == M_AT + 1) ref_at = {refresh_en, done};
            if (k == M_AT + 2) done_at = {refresh_en, done};
            @(negedge clk);
        end

        chk(n_iss == NCMD, "R11", "command count with extra start", n_iss, NCMD);
        chk(bad_ix < 0, "R2", "NOP then PRECHARGE after wait (cmd*1e6+cycle)",
            bad_act_c * 1000000 + bad_act_t,
            (bad_ix < 0) ? 0 : exp_cmd(bad_ix) * 1000000 + exp_time(bad_ix));
        chk(bad_ix < 0, "R3", "command order index mismatch", bad_ix, -1);
        chk(bad_ix < 0 || bad_ix <= 1, "R4", "refresh/mode spacing index", bad_ix, -1);
        chk(stray_cmd == 0, "R5", "non-NOP outside issue cycles", stray_cmd, 0);
        chk(stray_mode == 0, "R6", "mode data outside MRS", stray_mode, 0);
        if (ovr != 8'd0)
            chk(mrs_val == exp_m, "R7", "override mode value", mrs_val, exp_m);
        else
            chk(mrs_val == exp_m, "R6", "computed mode value", mrs_val, exp_m);
        chk(mrs_val == exp_m, "R8", "mode from captured config", mrs_val, exp_m);
        chk(ref_early == 0, "R9", "refresh_en during sequence", ref_early, 0);
        chk(ref_at == 2, "R9", "refresh_en=1 done=0 after MRS", ref_at, 2);
        chk(done_at == 3, "R10", "done one cycle after refresh", done_at, 3);

        // R11: start after done is ignored
        begin
            int extra = 0, lost = 0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 20; k++) begin
                if (cmd_issue) extra++;
                if (!done || !refresh_en) lost++;
                @(negedge clk);
            end
            chk(extra == 0, "R11", "commands after done-state start", extra, 0);
            chk(lost == 0, "R10", "done/refresh held after start", lost, 0);
        end
    endtask

    initial begin
        for (int c = 0; c < 8; c++)
            for (int h = 0; h < 2; h++)
                run_seq(3'(c), h[0], 8'd0);
        run_seq(3'd2, 1'b1, 8'h5A);
        run_seq(3'd7, 1'b0, 8'h01);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog (R2): actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule